// File: doc/BRIEF.md
# Multi-Channel Memory Clear Controller

This block sits beside up to four external memory channels. It shows software each channel's initialization-complete and calibration-failure flags, and it can wipe a channel's memory on request. A host reaches it over a plain 64-bit register bus with a byte address, a read strobe and a write strobe. Read data comes back registered, one cycle after the strobe.

Setting a bit in the low field of the control word starts a zero-fill engine on that channel. The engine drives the channel's own write port and writes one zero word per clock, going from address 0 up to the last word. A busy flag in the status word is set for the whole fill. Software polls this flag to learn when the wipe is finished, for example before the device is reprogrammed. The low control field cannot be read back as written. A read of it returns the build-time map of the channels that are fitted.

Top module: `memwipe_ctrl`

## Requirements
- R1: Synchronous reset clears every busy flag and the control storage bits 63:4. No memory write strobe is active during or just after reset. Reset leaves memory contents untouched.
- R2: A read of byte offset 0x08 returns the status word. Bits 0..3 carry init-done, bits 8..11 carry calibration-fail and bits 16..19 carry clear-busy, with bit n in each field belonging to channel n. Flags of absent channels read 0, and so do all other bits.
- R3: At byte offset 0x10, bits 63:4 are read/write storage and hold their value until the next write to that offset. Bits 3:0 always read the presence bitmap parameter (default 4'b1011), whatever was written to them.
- R4: Read data appears on the data output in the cycle after the read strobe. It is zero in any cycle that follows no read strobe, and zero after a read of any offset other than 0x08 and 0x10.
- R5: A write to 0x10 with bit n set, when channel n is present and idle, sets busy n in the next cycle. The engine then asserts write enable with addresses 0,1,..,WORDS-1 on consecutive cycles. Busy drops in the cycle after the last write, and every word of that memory then holds zero.
- R6: A channel's write enable is high only during its fill, and the write data is always zero.
- R7: A clear request to a channel that is already busy is ignored. The running fill is neither restarted nor lengthened, so exactly WORDS writes occur.
- R8: A clear request to an absent channel is ignored: its busy flag stays 0 and its memory sees no write.
- R9: Channels fill independently. Several requests in one write run at the same time, and a fill on one channel never writes to another channel.
- R10: Writes to offsets other than 0x10 change neither the control storage nor any busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data, valid the cycle after bus_rd |
| init_done | input | NUM_CH | Per-channel initialization-complete flags |
| cal_fail | input | NUM_CH | Per-channel calibration-failure flags |
| mem_we | output | NUM_CH | Per-channel memory write enable |
| mem_addr | output | NUM_CH*AW | Per-channel word address, channel n in slice n |
| mem_wdata | output | NUM_CH*DATA_W | Per-channel write data, always zero |

## Verification
The assertions check the engine's write-port stepping on every cycle: a fill starts at address 0, advances by exactly one address per clock, stops after the last word, and always carries zero data. They also check that absent channels never write, and that the read data is zero after idle or unmapped cycles and shows the presence map after control reads. Some behaviour is visible only in the bench's scenarios. That covers a second request landing on a busy channel, concurrent fills, unmapped writes leaving state alone, reset in the middle of a fill, and the channel memories ending up all zero. The bench shows this by comparing a behavioural model on every clock and by counting writes into its own copy of each memory.

// File: rtl/memwipe_pkg.sv
package memwipe_pkg;

    localparam int MAX_CH      = 4;
    localparam int BUS_W       = 64;
    localparam int OFS_STATUS  = 8;
    localparam int OFS_CTRL    = 16;
    localparam int STAT_INIT_LSB = 0;
    localparam int STAT_CAL_LSB  = 8;
    localparam int STAT_BUSY_LSB = 16;
    localparam int CTRL_CLR_W    = 4;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_state_e;

    typedef struct packed {
        logic rd_stat;
        logic rd_ctrl;
        logic wr_ctrl;
    } bus_dec_t;

    function automatic logic [BUS_W-1:0] pack_status(
        input logic [MAX_CH-1:0] init_v,
        input logic [MAX_CH-1:0] cal_v,
        input logic [MAX_CH-1:0] busy_v
    );
        logic [BUS_W-1:0] w;
        w = '0;
        w[STAT_INIT_LSB +: MAX_CH] = init_v;
        w[STAT_CAL_LSB  +: MAX_CH] = cal_v;
        w[STAT_BUSY_LSB +: MAX_CH] = busy_v;
        return w;
    endfunction

endpackage

// File: rtl/memwipe_regs.sv
module memwipe_regs
    import memwipe_pkg::*;
#(
    parameter int                NUM_CH     = 4,
    parameter int                ADDR_W     = 8,
    parameter logic [NUM_CH-1:0] CH_PRESENT = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0] init_done,
    input  logic [NUM_CH-1:0] cal_fail,
    input  logic [NUM_CH-1:0] busy,
    output logic [NUM_CH-1:0] clr_req
);

    bus_dec_t                     dec;
    logic [BUS_W-1:CTRL_CLR_W]    ctrl_keep;
    logic [MAX_CH-1:0]            init_w;
    logic [MAX_CH-1:0]            cal_w;
    logic [MAX_CH-1:0]            busy_w;
    logic [CTRL_CLR_W-1:0]        present_w;
    logic [BUS_W-1:0]             rd_val;

    always_comb begin
        dec.rd_stat = bus_rd && (bus_addr == ADDR_W'(OFS_STATUS));
        dec.rd_ctrl = bus_rd && (bus_addr == ADDR_W'(OFS_CTRL));
        dec.wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    end

    always_comb begin
        init_w    = '0;
        cal_w     = '0;
        busy_w    = '0;
        present_w = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            init_w[i]    = init_done[i] & CH_PRESENT[i];
            cal_w[i]     = cal_fail[i]  & CH_PRESENT[i];
            busy_w[i]    = busy[i];
            present_w[i] = CH_PRESENT[i];
        end
    end

    always_comb begin
        if (dec.rd_stat)
            rd_val = pack_status(init_w, cal_w, busy_w);
        else if (dec.rd_ctrl)
            rd_val = {ctrl_keep, present_w};
        else
            rd_val = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            ctrl_keep <= '0;
        end else begin
            bus_rdata <= rd_val;
            if (dec.wr_ctrl)
                ctrl_keep <= bus_wdata[BUS_W-1:CTRL_CLR_W];
        end
    end

    assign clr_req = dec.wr_ctrl ? (bus_wdata[NUM_CH-1:0] & CH_PRESENT) : '0;

endmodule

// File: rtl/memwipe_fill.sv
module memwipe_fill
    import memwipe_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int AW     = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              we,
    output logic [AW-1:0]     addr,
    output logic [DATA_W-1:0] wdata
);

    localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

    fill_state_e   state;
    logic [AW-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FILL_IDLE;
            ptr   <= '0;
        end else begin
            case (state)
                FILL_IDLE: begin
                    if (start) begin
                        state <= FILL_RUN;
                        ptr   <= '0;
                    end
                end
                FILL_RUN: begin
                    if (ptr == LAST)
                        state <= FILL_IDLE;
                    else
                        ptr <= ptr + 1'b1;
                end
                default: state <= FILL_IDLE;
            endcase
        end
    end

    assign busy  = (state == FILL_RUN);
    assign we    = busy;
    assign addr  = ptr;
    assign wdata = '0;

endmodule

// File: rtl/memwipe_ctrl.sv
module memwipe_ctrl
    import memwipe_pkg::*;
#(
    parameter int                NUM_CH     = 4,
    parameter int                ADDR_W     = 8,
    parameter int                MEM_WORDS  = 16,
    parameter int                DATA_W     = 64,
    parameter logic [NUM_CH-1:0] CH_PRESENT = 4'b1011,
    localparam int               AW         = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [63:0]              bus_wdata,
    output logic [63:0]              bus_rdata,
    input  logic [NUM_CH-1:0]        init_done,
    input  logic [NUM_CH-1:0]        cal_fail,
    output logic [NUM_CH-1:0]        mem_we,
    output logic [NUM_CH*AW-1:0]     mem_addr,
    output logic [NUM_CH*DATA_W-1:0] mem_wdata
);

    logic [NUM_CH-1:0] busy;
    logic [NUM_CH-1:0] clr_req;

    memwipe_regs #(
        .NUM_CH     (NUM_CH),
        .ADDR_W     (ADDR_W),
        .CH_PRESENT (CH_PRESENT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .init_done (init_done),
        .cal_fail  (cal_fail),
        .busy      (busy),
        .clr_req   (clr_req)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        memwipe_fill #(
            .WORDS  (MEM_WORDS),
            .AW     (AW),
            .DATA_W (DATA_W)
        ) u_fill (
            .clk   (clk),
            .rst   (rst),
            .start (clr_req[ch]),
            .busy  (busy[ch]),
            .we    (mem_we[ch]),
            .addr  (mem_addr[ch*AW +: AW]),
            .wdata (mem_wdata[ch*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/memwipe_chk.sv
module memwipe_chk #(
    parameter int                NUM_CH     = 4,
    parameter int                ADDR_W     = 8,
    parameter int                MEM_WORDS  = 16,
    parameter int                AW         = 4,
    parameter int                DATA_W     = 64,
    parameter logic [NUM_CH-1:0] CH_PRESENT = '1
) (
    input logic                     clk,
    input logic                     rst,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_rd,
    input logic [63:0]              bus_rdata,
    input logic [NUM_CH-1:0]        mem_we,
    input logic [NUM_CH*AW-1:0]     mem_addr,
    input logic [NUM_CH*DATA_W-1:0] mem_wdata
);

    localparam logic [AW-1:0] LAST = AW'(MEM_WORDS - 1);

    p_idle_rdata_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == '0);

    p_unmapped_read_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr != ADDR_W'(8) && bus_addr != ADDR_W'(16)) |=> bus_rdata == '0);

    p_ctrl_presence_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(16)) |=> bus_rdata[NUM_CH-1:0] == CH_PRESENT);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> mem_we == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        p_zero_data_r6: assert property (@(posedge clk) disable iff (rst)
            mem_we[c] |-> mem_wdata[c*DATA_W +: DATA_W] == '0);

        p_start_zero_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(mem_we[c]) |-> mem_addr[c*AW +: AW] == '0);

        p_step_one_r7: assert property (@(posedge clk) disable iff (rst)
            (mem_we[c] && mem_addr[c*AW +: AW] != LAST)
            |=> (mem_we[c] && mem_addr[c*AW +: AW] == $past(mem_addr[c*AW +: AW]) + 1'b1));

        p_stop_after_last_r5: assert property (@(posedge clk) disable iff (rst)
            (mem_we[c] && mem_addr[c*AW +: AW] == LAST) |=> !mem_we[c]);

        if (!CH_PRESENT[c]) begin : g_absent
            p_absent_silent_r8: assert property (@(posedge clk) disable iff (rst)
                !mem_we[c]);
        end
    end

endmodule

bind memwipe_ctrl memwipe_chk #(
    .NUM_CH     (NUM_CH),
    .ADDR_W     (ADDR_W),
    .MEM_WORDS  (MEM_WORDS),
    .AW         (AW),
    .DATA_W     (DATA_W),
    .CH_PRESENT (CH_PRESENT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/sim_memwipe_ctrl.sv
module sim_memwipe_ctrl;

    localparam int         NCH   = 4;
    localparam int         WORDS = 16;
    localparam int         AWB   = 4;
    localparam int         DW    = 64;
    localparam logic [3:0] PRES  = 4'b1011;
    localparam logic [63:0] FILLPAT = 64'hA5A5_5A5A_C3C3_3C3C;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [7:0]     bus_addr = '0;
    logic           bus_rd = 1'b0;
    logic           bus_wr = 1'b0;
    logic [63:0]    bus_wdata = '0;
    logic [63:0]    bus_rdata;
    logic [3:0]     init_done = '0;
    logic [3:0]     cal_fail = '0;
    logic [3:0]     mem_we;
    logic [NCH*AWB-1:0] mem_addr;
    logic [NCH*DW-1:0]  mem_wdata;

    always #2 clk = ~clk;

    memwipe_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .init_done(init_done), .cal_fail(cal_fail), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] exp_status(input logic [3:0] ini, input logic [3:0] cal, input logic [3:0] bsy);
        return {44'b0, bsy, 4'b0, cal & PRES, 4'b0, ini & PRES};
    endfunction

    // behavioural reference model and memory copies
    bit          m_busy [NCH];
    int          m_ptr  [NCH];
    logic [63:0] m_ctrl;
    logic [63:0] m_rdata;
    logic [63:0] mem [NCH][WORDS];
    int          wr_count [NCH];
    bit          loaded = 1'b0;

    always @(posedge clk) begin : model
        logic [63:0] rv;
        logic [3:0]  bv;
        if (!loaded) begin
            for (int c = 0; c < NCH; c++) begin
                wr_count[c] = 0;
                for (int w = 0; w < WORDS; w++) mem[c][w] = FILLPAT;
            end
            loaded = 1'b1;
        end
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin m_busy[c] = 0; m_ptr[c] = 0; end
            m_ctrl  = '0;
            m_rdata = '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (mem_we[c]) begin
                    mem[c][mem_addr[c*AWB +: AWB]] = mem_wdata[c*DW +: DW];
                    wr_count[c]++;
                end
            end
            for (int c = 0; c < NCH; c++) bv[c] = m_busy[c];
            rv = '0;
            if (bus_rd && bus_addr == 8'h08) rv = exp_status(init_done, cal_fail, bv);
            else if (bus_rd && bus_addr == 8'h10) rv = {m_ctrl[63:4], PRES};
            m_rdata = rv;
            for (int c = 0; c < NCH; c++) begin
                if (m_busy[c]) begin
                    if (m_ptr[c] == WORDS - 1) m_busy[c] = 0;
                    else m_ptr[c]++;
                end else if (bus_wr && bus_addr == 8'h10 && bus_wdata[c] && PRES[c]) begin
                    m_busy[c] = 1;
                    m_ptr[c]  = 0;
                end
            end
            if (bus_wr && bus_addr == 8'h10) m_ctrl = {bus_wdata[63:4], 4'b0};
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && loaded) begin
            chk(bus_rdata == m_rdata, "R4 rdata", bus_rdata, m_rdata);
            for (int c = 0; c < NCH; c++) begin
                chk(mem_we[c] == m_busy[c], "R5 write enable", 64'(mem_we[c]), 64'(m_busy[c]));
                if (m_busy[c]) begin
                    chk(mem_addr[c*AWB +: AWB] == AWB'(m_ptr[c]), "R5 write address",
                        64'(mem_addr[c*AWB +: AWB]), 64'(m_ptr[c]));
                    chk(mem_wdata[c*DW +: DW] == '0, "R6 write data", mem_wdata[c*DW +: DW], 64'd0);
                end
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R5 watchdog actual=%0d expected=%0d", 20000, 0);
        finish_run();
    end

    localparam logic [63:0] KEEP = 64'hDEAD_BEEF_0000_0F00;

    initial begin : main
        logic [63:0] d;
        int base [NCH];
        bit allz;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        bus_read(8'h08, d); chk(d == 64'h0, "R1 status after reset", d, 64'h0);
        bus_read(8'h10, d); chk(d == 64'hB, "R1 control after reset", d, 64'hB);

        // R2: status flags with absent channel masked
        init_done = 4'hF; cal_fail = 4'h6;
        bus_read(8'h08, d); chk(d == 64'h020B, "R2 status flags", d, 64'h020B);

        // R3: storage bits hold, low field shows presence map
        bus_write(8'h10, KEEP | 64'h4);
        // bit2 absent: no fill expected
        bus_read(8'h10, d); chk(d == (KEEP | 64'hB), "R3 control readback", d, KEEP | 64'hB);

        // R5: single-channel fill
        for (int c = 0; c < NCH; c++) base[c] = wr_count[c];
        bus_write(8'h10, KEEP | 64'h1);
        bus_read(8'h08, d); chk(d == 64'h1020B, "R5 busy set", d, 64'h1020B);
        repeat (20) @(negedge clk);
        bus_read(8'h08, d); chk(d == 64'h020B, "R5 busy cleared", d, 64'h020B);
        chk(wr_count[0] - base[0] == WORDS, "R5 write count", 64'(wr_count[0] - base[0]), 64'(WORDS));
        allz = 1;
        for (int w = 0; w < WORDS; w++) if (mem[0][w] != '0) allz = 0;
        chk(allz, "R5 memory zeroed", 64'(allz), 64'd1);
        chk(mem[1][0] == FILLPAT, "R9 other channel untouched", mem[1][0], FILLPAT);
        chk(wr_count[2] == 0, "R8 absent channel no writes", 64'(wr_count[2]), 64'd0);

        // R7: second request while busy is ignored
        for (int c = 0; c < NCH; c++) base[c] = wr_count[c];
        bus_write(8'h10, KEEP | 64'h2);
        repeat (4) @(negedge clk);
        bus_write(8'h10, KEEP | 64'h2);
        repeat (20) @(negedge clk);
        chk(wr_count[1] - base[1] == WORDS, "R7 no restart", 64'(wr_count[1] - base[1]), 64'(WORDS));

        // R8: absent channel request
        bus_write(8'h10, KEEP | 64'h4);
        bus_read(8'h08, d); chk(d == 64'h020B, "R8 absent not busy", d, 64'h020B);
        repeat (20) @(negedge clk);
        chk(wr_count[2] == 0, "R8 absent no writes", 64'(wr_count[2]), 64'd0);
        chk(mem[2][0] == FILLPAT, "R8 absent memory intact", mem[2][0], FILLPAT);

        // R9: concurrent fills
        for (int c = 0; c < NCH; c++) base[c] = wr_count[c];
        bus_write(8'h10, KEEP | 64'hB);
        bus_read(8'h08, d); chk(d == 64'hB020B, "R9 all busy", d, 64'hB020B);
        repeat (20) @(negedge clk);
        bus_read(8'h08, d); chk(d == 64'h020B, "R9 all done", d, 64'h020B);
        for (int c = 0; c < NCH; c++) begin
            chk(wr_count[c] - base[c] == (PRES[c] ? WORDS : 0), "R9 per-channel count",
                64'(wr_count[c] - base[c]), 64'(PRES[c] ? WORDS : 0));
        end

        // R10 / R4: unmapped offsets
        bus_write(8'h18, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_write(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(8'h10, d); chk(d == (KEEP | 64'hB), "R10 control unchanged", d, KEEP | 64'hB);
        bus_read(8'h08, d); chk(d == 64'h020B, "R10 no busy", d, 64'h020B);
        bus_read(8'h00, d); chk(d == 64'h0, "R4 unmapped read 0x00", d, 64'h0);
        bus_read(8'h18, d); chk(d == 64'h0, "R4 unmapped read 0x18", d, 64'h0);
        @(negedge clk);
        chk(bus_rdata == 64'h0, "R4 idle rdata", bus_rdata, 64'h0);

        // R1: reset in the middle of a fill
        bus_write(8'h10, KEEP | 64'h8);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(mem_we == 4'h0, "R1 no writes in reset", 64'(mem_we), 64'h0);
        rst = 1'b0;
        bus_read(8'h08, d); chk(d == 64'h020B, "R1 busy cleared by reset", d, 64'h020B);
        bus_read(8'h10, d); chk(d == 64'hB, "R1 storage cleared by reset", d, 64'hB);
        chk(mem[2][5] == FILLPAT, "R1 memory kept across reset", mem[2][5], FILLPAT);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule